// File: doc/BRIEF.md
# Circular trace capture buffer

The block stores a stream of trace words in an on-chip ring memory. On each cycle where a word is offered and capture is running, the word is written at the write pointer and the pointer moves on by one, wrapping at the end of the memory. Once the pointer has wrapped, a sticky flag records that old entries have been overwritten. Software then knows whether the oldest entry is at the write pointer or at address 0.

A trigger input marks the event of interest. After the trigger, a programmable counter counts down once per stored word. When it runs out, the acquisition is marked complete and capture stops. The memory can then be read back through the register port. Each read of the data register returns the entry at the read pointer and advances that pointer.

The register port has a request strobe, a write flag, a 7-bit register address and 32-bit write data. Read data is registered and is valid in the cycle after the request. A status bit shows the sampled level of a formatter-empty input.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, the status, control, trigger count, read pointer and write pointer registers all read 0, and reg_rdata_o is 0.
- R2: Read data appears on reg_rdata_o one cycle after a read request. Address 0 returns the ID_VAL parameter, address 1 returns DEPTH, and address 2 returns WIDTH.
- R3: While control bit 0 is 1 and status bit 2 is 0, each cycle with cap_valid_i high stores cap_data_i at the write pointer and advances the write pointer by one modulo DEPTH. Otherwise the offered word is ignored and the write pointer stays where it is.
- R4: Status bit 0 (full) is set when a word is stored at address DEPTH-1. It stays set until the enable bit rises.
- R5: Status bit 1 (triggered) is set when trig_i is high while capture is enabled and not complete. trig_i has no effect while control bit 0 is 0.
- R6: Address 7 holds the post-trigger count. Each word stored in or after the trigger cycle decrements it, stopping at 0. The word that takes the count from 1 to 0 (or any stored trigger-cycle word when the count is already 0) sets status bit 2 (complete). While complete is set, nothing more is stored and capturing_o is 0.
- R7: Status bit 3 shows fmt_empty_i as registered at the previous clock edge.
- R8: A read of address 4 returns the stored word at the read pointer, zero-extended. It then advances the read pointer by one modulo DEPTH.
- R9: Address 5 (read pointer) and address 6 (write pointer) can be written and read back.
- R10: Control (address 8) bit 0 enables capture and bit 1 drives demux_o. Writing a 1 to bit 0 while it was 0 clears status bits 0 to 2.
- R11: Addresses 9 and above read as 0. Writes to addresses 0 to 4 and 9 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_valid_i | input | 1 | A trace word is offered this cycle |
| cap_data_i | input | WIDTH | The trace word |
| trig_i | input | 1 | Trigger event |
| fmt_empty_i | input | 1 | Formatter-empty level |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| demux_o | output | 1 | Port-mode select from control bit 1 |
| capturing_o | output | 1 | Enabled and not complete |

## Verification
The assertions assume that software does not write the write pointer, the control register or the trigger counter in the same cycle as a capture word. They also assume that DEPTH is a power of two, so a written pointer value is always in range. The bench keeps these conditions by running register accesses and capture words in separate cycles, each task using its own cycle. It also stops capture before it reprograms the pointers or the count.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int unsigned REG_AW = 7;
  localparam logic [REG_AW-1:0] A_IDENT = 7'd0;
  localparam logic [REG_AW-1:0] A_DEPTH = 7'd1;
  localparam logic [REG_AW-1:0] A_WIDTH = 7'd2;
  localparam logic [REG_AW-1:0] A_STAT  = 7'd3;
  localparam logic [REG_AW-1:0] A_DATA  = 7'd4;
  localparam logic [REG_AW-1:0] A_RPTR  = 7'd5;
  localparam logic [REG_AW-1:0] A_WPTR  = 7'd6;
  localparam logic [REG_AW-1:0] A_TCNT  = 7'd7;
  localparam logic [REG_AW-1:0] A_CTRL  = 7'd8;

  typedef struct packed {
    logic fmt_empty;
    logic done;
    logic trig_seen;
    logic full;
  } stat_t;
endpackage

// File: rtl/trb_ptr.sv
module trb_ptr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic          step_i,
  output logic [PW-1:0] ptr_o,
  output logic          last_o
);
  assign last_o = (ptr_o == PW'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (load_i)  ptr_o <= load_val_i;
    else if (step_i)  ptr_o <= last_o ? '0 : ptr_o + PW'(1);
  end
endmodule

// File: rtl/trb_store.sv
module trb_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 24,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trb_acq.sv
module trb_acq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [1:0]  ctrl_wdata_i,
  input  logic        tcnt_we_i,
  input  logic [31:0] tcnt_wdata_i,
  input  logic        cap_valid_i,
  input  logic        trig_i,
  input  logic        wp_last_i,
  output logic        accept_o,
  output logic        en_o,
  output logic        demux_o,
  output logic        trig_seen_o,
  output logic        done_o,
  output logic        full_o,
  output logic [31:0] tcnt_o
);
  logic en_rise, live, armed;

  assign en_rise  = ctrl_we_i && ctrl_wdata_i[0] && !en_o;
  assign live     = en_o && !done_o;
  assign accept_o = live && cap_valid_i;
  // words stored in the trigger cycle already count
  assign armed    = trig_seen_o || trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      demux_o <= 1'b0;
    end else if (ctrl_we_i) begin
      en_o    <= ctrl_wdata_i[0];
      demux_o <= ctrl_wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_seen_o <= 1'b0;
      done_o      <= 1'b0;
      full_o      <= 1'b0;
    end else if (en_rise) begin
      trig_seen_o <= 1'b0;
      done_o      <= 1'b0;
      full_o      <= 1'b0;
    end else begin
      if (live && trig_i)                 trig_seen_o <= 1'b1;
      if (accept_o && wp_last_i)          full_o      <= 1'b1;
      if (accept_o && armed && tcnt_o <= 32'd1) done_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    tcnt_o <= '0;
    else if (tcnt_we_i)                             tcnt_o <= tcnt_wdata_i;
    else if (accept_o && armed && tcnt_o != 32'd0)  tcnt_o <= tcnt_o - 32'd1;
  end
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WIDTH  = 24,
  parameter logic [31:0] ID_VAL = 32'h7B10_0A01,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_valid_i,
  input  logic [WIDTH-1:0] cap_data_i,
  input  logic             trig_i,
  input  logic             fmt_empty_i,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [6:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             demux_o,
  output logic             capturing_o
);
  import trb_pkg::*;

  logic wr_acc, rd_acc;
  logic ctrl_we, tcnt_we, wp_we, rp_we, data_rd;
  logic accept, en, trig_seen, done, full, fmt_q;
  logic wp_last, rp_last;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] ram_rdata;
  logic [31:0] tcnt, rd_mux;
  stat_t stat;

  assign wr_acc  = reg_req_i && reg_we_i;
  assign rd_acc  = reg_req_i && !reg_we_i;
  assign ctrl_we = wr_acc && (reg_addr_i == A_CTRL);
  assign tcnt_we = wr_acc && (reg_addr_i == A_TCNT);
  assign wp_we   = wr_acc && (reg_addr_i == A_WPTR);
  assign rp_we   = wr_acc && (reg_addr_i == A_RPTR);
  assign data_rd = rd_acc && (reg_addr_i == A_DATA);

  trb_acq u_acq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (reg_wdata_i[1:0]),
    .tcnt_we_i    (tcnt_we),
    .tcnt_wdata_i (reg_wdata_i),
    .cap_valid_i  (cap_valid_i),
    .trig_i       (trig_i),
    .wp_last_i    (wp_last),
    .accept_o     (accept),
    .en_o         (en),
    .demux_o      (demux_o),
    .trig_seen_o  (trig_seen),
    .done_o       (done),
    .full_o       (full),
    .tcnt_o       (tcnt)
  );

  trb_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wp_we),
    .load_val_i (reg_wdata_i[PW-1:0]),
    .step_i     (accept),
    .ptr_o      (wr_ptr),
    .last_o     (wp_last)
  );

  trb_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rp_we),
    .load_val_i (reg_wdata_i[PW-1:0]),
    .step_i     (data_rd),
    .ptr_o      (rd_ptr),
    .last_o     (rp_last)
  );

  trb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (wr_ptr),
    .wdata_i (cap_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_q <= 1'b0;
    else         fmt_q <= fmt_empty_i;
  end

  assign stat = '{fmt_empty: fmt_q, done: done, trig_seen: trig_seen, full: full};
  assign capturing_o = en && !done;

  always_comb begin
    unique case (reg_addr_i)
      A_IDENT: rd_mux = ID_VAL;
      A_DEPTH: rd_mux = 32'(DEPTH);
      A_WIDTH: rd_mux = 32'(WIDTH);
      A_STAT:  rd_mux = {28'd0, stat};
      A_DATA:  rd_mux = 32'(ram_rdata);
      A_RPTR:  rd_mux = 32'(rd_ptr);
      A_WPTR:  rd_mux = 32'(wr_ptr);
      A_TCNT:  rd_mux = tcnt;
      A_CTRL:  rd_mux = {30'd0, demux_o, en};
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reg_rdata_o <= '0;
    else if (rd_acc) reg_rdata_o <= rd_mux;
  end

  logic unused_ok;
  assign unused_ok = rp_last;
endmodule

// File: rtl/trb_chk.sv
module trb_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_req_i,
  input logic          reg_we_i,
  input logic [6:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [31:0]   reg_rdata_o,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          en,
  input logic          full,
  input logic          done,
  input logic          trig_seen,
  input logic          capturing_o
);
  logic sw_touch;
  assign sw_touch = reg_req_i && reg_we_i && (reg_addr_i == 7'd6 || reg_addr_i == 7'd8);

  // R2
  depth_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == 7'd1 |=> reg_rdata_o == 32'(DEPTH));

  // R4
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !(reg_req_i && reg_we_i && reg_addr_i == 7'd8 && reg_wdata_i[0] && !en) |=> full);

  // R5
  trig_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_seen) |-> $past(en));

  // R6
  done_freezes_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !sw_touch |=> $stable(wr_ptr));

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !capturing_o);

  // R8
  data_read_moves_rp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == 7'd4 && DEPTH > 1 |=> !$stable(rd_ptr));
endmodule

bind trace_ring_buf trb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .en          (en),
  .full        (full),
  .done        (done),
  .trig_seen   (trig_seen),
  .capturing_o (capturing_o)
);

// File: tb/trace_ring_buf_test.sv
module trace_ring_buf_test;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned WIDTH = 24;
  localparam logic [31:0] ID_VAL = 32'h7B10_0A01;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cap_valid_i = 0, trig_i = 0, fmt_empty_i = 0;
  logic [WIDTH-1:0] cap_data_i = '0;
  logic reg_req_i = 0, reg_we_i = 0;
  logic [6:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic demux_o, capturing_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VAL(ID_VAL)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    @(negedge clk_i);
    reg_req_i = 0;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic push(input logic [WIDTH-1:0] d, input logic t);
    @(negedge clk_i);
    cap_valid_i = 1; cap_data_i = d; trig_i = t;
    @(negedge clk_i);
    cap_valid_i = 0; trig_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rdata", reg_rdata_o, 0);
    rd(7'd3, d); chk("R1 status", d, 0);
    rd(7'd5, d); chk("R1 rptr", d, 0);
    rd(7'd6, d); chk("R1 wptr", d, 0);
    rd(7'd7, d); chk("R1 tcnt", d, 0);
    rd(7'd8, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_const;
    logic [31:0] d;
    rd(7'd0, d); chk("R2 ident", d, ID_VAL);
    rd(7'd1, d); chk("R2 depth", d, DEPTH);
    rd(7'd2, d); chk("R2 width", d, WIDTH);
    wr(7'd1, 32'h55); wr(7'd12, 32'h3);
    rd(7'd1, d); chk("R11 depth after write", d, DEPTH);
    rd(7'd12, d); chk("R11 unmapped", d, 0);
    rd(7'd8, d); chk("R11 ctrl untouched", d, 0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    push(24'hAAAA, 1'b1);
    rd(7'd3, d); chk("R5 trig while disabled", d, 0);
    rd(7'd6, d); chk("R3 disabled no store", d, 0);
    wr(7'd7, 32'd1000); wr(7'd8, 32'd1);
    for (int i = 0; i < 5; i++) push(WIDTH'(24'h100 + i * 24'h11), 1'b0);
    rd(7'd6, d); chk("R3 wptr", d, 5);
    wr(7'd5, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(7'd4, d); chk("R8 data", d, 32'h100 + i * 32'h11);
    end
    rd(7'd5, d); chk("R8 rptr advanced", d, 5);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(7'd8, 32'd0); wr(7'd6, 32'd0);
    rd(7'd6, d); chk("R9 wptr write", d, 0);
    wr(7'd8, 32'd1);
    for (int i = 0; i < DEPTH + 3; i++) push(WIDTH'(i), 1'b0);
    rd(7'd3, d); chk("R4 full", d, 32'h1);
    rd(7'd6, d); chk("R3 wrapped wptr", d, 3);
    wr(7'd5, 32'd3);
    rd(7'd5, d); chk("R9 rptr write", d, 3);
    for (int i = 0; i < DEPTH; i++) begin
      rd(7'd4, d); chk("R8 oldest-first", d, 32'(i + 3));
    end
    rd(7'd5, d); chk("R8 rptr wrap", d, 3);
  endtask

  task automatic t_trigger;
    logic [31:0] d;
    wr(7'd8, 32'd0); wr(7'd7, 32'd3); wr(7'd6, 32'd0);
    wr(7'd8, 32'd1);
    rd(7'd3, d); chk("R10 rise clears flags", d, 0);
    push(24'h1, 0); push(24'h2, 0);
    push(24'h3, 1);
    rd(7'd3, d); chk("R5 triggered", d, 32'h2);
    chk("R6 still capturing", 32'(capturing_o), 1);
    push(24'h4, 0); push(24'h5, 0);
    push(24'h6, 0); push(24'h7, 0);
    rd(7'd3, d); chk("R6 complete", d, 32'h6);
    rd(7'd6, d); chk("R6 wptr stops", d, 5);
    rd(7'd7, d); chk("R6 count zero", d, 0);
    chk("R6 capturing low", 32'(capturing_o), 0);
    wr(7'd5, 32'd4);
    rd(7'd4, d); chk("R6 last stored word", d, 32'h5);
  endtask

  task automatic t_fmt_ctrl;
    logic [31:0] d;
    fmt_empty_i = 1;
    rd(7'd3, d); chk("R7 fmt empty set", d, 32'hE);
    fmt_empty_i = 0;
    @(negedge clk_i);
    rd(7'd3, d); chk("R7 fmt empty clear", d, 32'h6);
    wr(7'd8, 32'd0); wr(7'd8, 32'd3);
    chk("R10 demux", 32'(demux_o), 1);
    rd(7'd8, d); chk("R10 ctrl", d, 3);
    rd(7'd3, d); chk("R10 flags cleared", d, 0);
    wr(7'd8, 32'd0);
    chk("R10 demux off", 32'(demux_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_const();
    t_capture();
    t_wrap();
    t_trigger();
    t_fmt_ctrl();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule